// File: doc/BRIEF.md
# I2C Switch Control Slave

This block is a bus slave on a two-wire I2C-compatible bus that owns one 8-bit register whose bits turn eight analog switches on or off. A bit at 1 closes its switch and a bit at 0 opens it. Bit 7 drives switch 8 and bit 0 drives switch 1. The block samples SCL and SDA with the fast system clock. It passes each line through a synchronizer and a stable-count filter. From the filtered levels it detects START, repeated START and STOP, and then runs the address, data and acknowledge phases.

The 7-bit slave address is a fixed 5-bit upper part, set by a parameter, followed by two pins. After a matching address with R/W = 0, each data byte is acknowledged and copied into the register at once, with a one-cycle update strobe. After a matching address with R/W = 1, the block returns the live register value, MSB first. The block never drives SDA high. It only raises an active-high pull-low enable, which the pad turns into an open-drain output.

Top module: `swreg_i2c`

## Requirements
- R1: While the synchronous active-high reset is asserted, and directly after it, `sw_ctrl` is 8'h00, `sw_upd` is 0 and `sda_pull` is 0.
- R2: The slave address is {ADDR_HI[4:0], adr_pin[1], adr_pin[0]}. The address byte is that address followed by the R/W bit in bit 0. On a match, the slave holds SDA low during the ninth SCL pulse.
- R3: On an address mismatch the slave does not acknowledge. It leaves SDA released and leaves `sw_ctrl` unchanged until the next START or STOP.
- R4: In a write, each data byte is received MSB first and acknowledged. `sw_ctrl` takes the byte with a single-cycle `sw_upd` pulse, and `sw_ctrl` changes at no other time.
- R5: Every data byte of a multi-byte write causes its own update, in bus order.
- R6: In a read, the slave sends the current `sw_ctrl` MSB first, pulling SDA low only for 0 bits. A master acknowledge repeats the byte. A master not-acknowledge ends the slave's driving.
- R7: A repeated START, with no STOP before it, always restarts the address phase, including after a mismatched address.
- R8: A pulse on SCL or SDA shorter than FILT_CYCLES system clocks neither clocks a bit nor forms a START or STOP.
- R9: `sda_pull` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| adr_pin | input | 2 | Two lowest address bits (bit 1, bit 0) |
| sda_pull | output | 1 | Pull SDA low when 1 |
| sw_ctrl | output | 8 | Switch control register, bit n drives switch n+1 |
| sw_upd | output | 1 | One-cycle strobe when sw_ctrl is loaded |

## Verification
Each bus edge reaches the protocol engine 2 synchronizer cycles plus FILT_CYCLES filter cycles after the pin changes. The update strobe and the acknowledge pull both appear one cycle after the filtered SCL fall that ends the eighth bit. A read bit appears one cycle after the filtered fall that starts its slot. The bench holds every SCL phase 30 cycles, well past that latency. It samples SDA halfway through SCL high, so each acknowledge and read bit is read while it is settled. A scoreboard collects the strobe whenever it fires and compares it against the queue of bytes the driver wrote. This checks order and count without relying on an exact update cycle.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WRITE,
        PH_READ,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lvl_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [6:0] rx,
                                      input logic [4:0] hi,
                                      input logic [1:0] pins);
        return rx == {hi, pins};
    endfunction

endpackage

// File: rtl/swreg_glitch_filt.sv
module swreg_glitch_filt #(
    parameter int   STABLE   = 12,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(STABLE + 1);

    logic [1:0]    sync;
    logic [CW-1:0] cnt;
    logic          q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync <= {2{IDLE_VAL}};
            cnt  <= '0;
            q    <= IDLE_VAL;
        end else begin
            sync <= {sync[0], din};
            if (sync[1] != q) begin
                if (cnt == CW'(STABLE - 1)) begin
                    q   <= sync[1];
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    assign dout = q;

    // filtered level only follows a synchronized level that held long enough
    AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(q) |-> (q == $past(sync[1])) && ($past(cnt) == CW'(STABLE - 1))); // R8

endmodule

// File: rtl/swreg_bus_events.sv
module swreg_bus_events
    import swreg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_lvl_t lvl,
    output bus_ev_t  ev
);
    bus_lvl_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= lvl;
    end

    always_comb begin
        ev.start = lvl.scl & prev.scl & prev.sda & ~lvl.sda;
        ev.stop  = lvl.scl & prev.scl & ~prev.sda & lvl.sda;
        ev.rise  = lvl.scl & ~prev.scl;
        ev.fall  = ~lvl.scl & prev.scl;
    end

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.start, ev.stop, ev.rise, ev.fall})); // R7

endmodule

// File: rtl/swreg_engine.sv
module swreg_engine
    import swreg_pkg::*;
#(
    parameter logic [4:0] ADDR_HI = 5'b10011
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_lvl_t          lvl,
    input  bus_ev_t           ev,
    input  logic [1:0]        pins,
    output logic [BYTE_W-1:0] ctrl,
    output logic              upd,
    output logic              pull
);
    localparam int BCW = $clog2(BYTE_W + 1);
    localparam logic [BCW-1:0] LAST = BCW'(BYTE_W);

    phase_t            phase;
    logic [BCW-1:0]    cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic              in_ack;
    logic              rd;
    logic              nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            sh     <= '0;
            tx     <= '0;
            ctrl   <= '0;
            upd    <= 1'b0;
            pull   <= 1'b0;
            in_ack <= 1'b0;
            rd     <= 1'b0;
            nack   <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (ev.start) begin
                phase  <= PH_ADDR;
                cnt    <= '0;
                in_ack <= 1'b0;
                pull   <= 1'b0;
            end else if (ev.stop) begin
                phase  <= PH_IDLE;
                cnt    <= '0;
                in_ack <= 1'b0;
                pull   <= 1'b0;
            end else if (ev.rise) begin
                if (!in_ack && cnt != LAST) begin
                    if (phase == PH_ADDR || phase == PH_WRITE)
                        sh <= {sh[BYTE_W-2:0], lvl.sda};
                    if (phase == PH_ADDR || phase == PH_WRITE || phase == PH_READ)
                        cnt <= cnt + 1'b1;
                end else if (in_ack && phase == PH_READ) begin
                    nack <= lvl.sda;
                end
            end else if (ev.fall) begin
                case (phase)
                    PH_ADDR: begin
                        if (in_ack) begin
                            in_ack <= 1'b0;
                            cnt    <= '0;
                            if (rd) begin
                                phase <= PH_READ;
                                tx    <= ctrl;
                                pull  <= ~ctrl[BYTE_W-1];
                            end else begin
                                phase <= PH_WRITE;
                                pull  <= 1'b0;
                            end
                        end else if (cnt == LAST) begin
                            if (addr_hit(sh[BYTE_W-1:1], ADDR_HI, pins)) begin
                                in_ack <= 1'b1;
                                pull   <= 1'b1;
                                rd     <= sh[0];
                            end else begin
                                phase <= PH_SKIP;
                            end
                        end
                    end
                    PH_WRITE: begin
                        if (in_ack) begin
                            in_ack <= 1'b0;
                            pull   <= 1'b0;
                            cnt    <= '0;
                        end else if (cnt == LAST) begin
                            ctrl   <= sh;
                            upd    <= 1'b1;
                            in_ack <= 1'b1;
                            pull   <= 1'b1;
                        end
                    end
                    PH_READ: begin
                        if (in_ack) begin
                            in_ack <= 1'b0;
                            if (nack) begin
                                phase <= PH_SKIP;
                                pull  <= 1'b0;
                            end else begin
                                cnt  <= '0;
                                tx   <= ctrl;
                                pull <= ~ctrl[BYTE_W-1];
                            end
                        end else if (cnt == LAST) begin
                            in_ack <= 1'b1;
                            pull   <= 1'b0;
                        end else begin
                            tx   <= {tx[BYTE_W-2:0], 1'b0};
                            pull <= ~tx[BYTE_W-2];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_UPD_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        upd |-> !lvl.scl); // R4
    AST_CTRL_WITH_UPD: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl) |-> upd); // R4
    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        upd |=> !upd); // R5
    AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !pull); // R3
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(pull) |-> !lvl.scl); // R9

endmodule

// File: rtl/swreg_i2c.sv
module swreg_i2c
    import swreg_pkg::*;
#(
    parameter logic [4:0] ADDR_HI     = 5'b10011,
    parameter int         FILT_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        adr_pin,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] sw_ctrl,
    output logic              sw_upd
);
    logic [1:0] raw;
    logic [1:0] filt;
    bus_lvl_t   lvl;
    bus_ev_t    ev;

    assign raw = {scl_i, sda_i};

    for (genvar gi = 0; gi < 2; gi++) begin : g_line
        swreg_glitch_filt #(
            .STABLE  (FILT_CYCLES),
            .IDLE_VAL(1'b1)
        ) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw[gi]),
            .dout(filt[gi])
        );
    end

    assign lvl.scl = filt[1];
    assign lvl.sda = filt[0];

    swreg_bus_events u_ev (
        .clk(clk),
        .rst(rst),
        .lvl(lvl),
        .ev (ev)
    );

    swreg_engine #(
        .ADDR_HI(ADDR_HI)
    ) u_eng (
        .clk (clk),
        .rst (rst),
        .lvl (lvl),
        .ev  (ev),
        .pins(adr_pin),
        .ctrl(sw_ctrl),
        .upd (sw_upd),
        .pull(sda_pull)
    );

endmodule

// File: tb/swreg_i2c_test.sv
`timescale 1ns/1ps
module swreg_i2c_test;

    localparam int Q = 30;
    localparam logic [7:0] WR_OK  = 8'h9C; // 1001110 + W
    localparam logic [7:0] RD_OK  = 8'h9D; // 1001110 + R
    localparam logic [7:0] WR_BAD = 8'h98; // 1001100 + W

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pull;
    logic [7:0] sw_ctrl;
    logic       sw_upd;
    logic       quiet = 1'b0;
    logic       done = 1'b0;
    int         errors = 0;
    int         checks = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    swreg_i2c uut (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .adr_pin (2'b10),
        .sda_pull(sda_pull),
        .sw_ctrl (sw_ctrl),
        .sw_upd  (sw_upd)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (sw_upd) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected update", sw_ctrl, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(sw_ctrl == e, "R5", "update value", sw_ctrl, e);
                end
            end
            if (quiet && sda_pull)
                check(1'b0, "R3", "pull during ignored byte", 1, 0);
        end
    end

    task automatic i2c_start;
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        sda_m = 1'b1; wait_cyc(Q);
    endtask

    // gm: 0 none, 1 SCL low spike, 2 SDA low spike, both on the first bit
    task automatic send_byte(input logic [7:0] b, input int gm, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_cyc(Q);
            scl_m = 1'b1; wait_cyc(Q / 2);
            if (i == 7 && gm == 1) begin
                scl_m = 1'b0; wait_cyc(4); scl_m = 1'b1;
            end
            if (i == 7 && gm == 2) begin
                sda_m = 1'b0; wait_cyc(4); sda_m = 1'b1;
            end
            wait_cyc(Q / 2);
            scl_m = 1'b0; wait_cyc(Q);
        end
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q / 2);
        ack = sda_line;
        wait_cyc(Q / 2);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_cyc(Q);
            scl_m = 1'b1; wait_cyc(Q / 2);
            b[i] = sda_line;
            wait_cyc(Q / 2);
            scl_m = 1'b0; wait_cyc(Q);
        end
        sda_m = nack; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b0; wait_cyc(Q);
        sda_m = 1'b1;
    endtask

    task automatic write_one(input logic [7:0] d, input int gm, input string req);
        logic a;
        exp_q.push_back(d);
        send_byte(d, gm, a);
        check(a == 1'b0, req, "data ack", a, 0);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        logic       a;
        logic [7:0] rb;

        // R1: reset state
        wait_cyc(5);
        check(sw_ctrl == 8'h00, "R1", "ctrl in reset", sw_ctrl, 0);
        check(sda_pull == 1'b0, "R1", "pull in reset", sda_pull, 0);
        rst = 1'b0;
        wait_cyc(3);
        check(sw_ctrl == 8'h00 && !sw_upd, "R1", "ctrl after reset", sw_ctrl, 0);

        // R2, R4: single write
        i2c_start;
        send_byte(WR_OK, 0, a);
        check(a == 1'b0, "R2", "address ack", a, 0);
        write_one(8'hA5, 0, "R4");
        i2c_stop;
        wait_cyc(Q);
        check(sw_ctrl == 8'hA5, "R4", "ctrl after write", sw_ctrl, 8'hA5);

        // R5: multi-byte write
        i2c_start;
        send_byte(WR_OK, 0, a);
        check(a == 1'b0, "R2", "address ack multi", a, 0);
        write_one(8'h01, 0, "R5");
        write_one(8'h80, 0, "R5");
        write_one(8'h5A, 0, "R5");
        i2c_stop;
        wait_cyc(Q);
        check(sw_ctrl == 8'h5A, "R5", "ctrl after last byte", sw_ctrl, 8'h5A);
        check(exp_q.size() == 0, "R5", "updates per byte", exp_q.size(), 0);

        // R6: read twice, master ack then nack
        i2c_start;
        send_byte(RD_OK, 0, a);
        check(a == 1'b0, "R2", "read address ack", a, 0);
        recv_byte(1'b0, rb);
        check(rb == 8'h5A, "R6", "read byte 1", rb, 8'h5A);
        recv_byte(1'b1, rb);
        check(rb == 8'h5A, "R6", "read byte 2", rb, 8'h5A);
        check(sda_pull == 1'b0, "R6", "released after nack", sda_pull, 0);
        i2c_stop;

        // R3: mismatched address
        i2c_start;
        send_byte(WR_BAD, 0, a);
        check(a == 1'b1, "R3", "no ack on mismatch", a, 1);
        quiet = 1'b1;
        send_byte(8'hFF, 0, a);
        check(a == 1'b1, "R3", "no data ack on mismatch", a, 1);
        quiet = 1'b0;
        i2c_stop;
        wait_cyc(Q);
        check(sw_ctrl == 8'h5A, "R3", "ctrl unchanged", sw_ctrl, 8'h5A);

        // R7: repeated START from write to read
        i2c_start;
        send_byte(WR_OK, 0, a);
        write_one(8'h3C, 0, "R7");
        i2c_start;
        send_byte(RD_OK, 0, a);
        check(a == 1'b0, "R7", "ack after repeated start", a, 0);
        recv_byte(1'b1, rb);
        check(rb == 8'h3C, "R7", "read after repeated start", rb, 8'h3C);
        i2c_stop;

        // R7: repeated START after mismatch
        i2c_start;
        send_byte(WR_BAD, 0, a);
        i2c_start;
        send_byte(WR_OK, 0, a);
        check(a == 1'b0, "R7", "ack after mismatch restart", a, 0);
        write_one(8'h77, 0, "R7");
        i2c_stop;
        wait_cyc(Q);
        check(sw_ctrl == 8'h77, "R7", "ctrl after restart write", sw_ctrl, 8'h77);

        // R8: spikes on SCL and SDA
        i2c_start;
        send_byte(WR_OK, 0, a);
        write_one(8'hC3, 1, "R8");
        write_one(8'h81, 2, "R8");
        i2c_stop;
        wait_cyc(Q);
        check(sw_ctrl == 8'h81, "R8", "ctrl after spikes", sw_ctrl, 8'h81);

        // R1: reset clears a written register
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
        check(sw_ctrl == 8'h00, "R1", "ctrl after late reset", sw_ctrl, 0);
        check(exp_q.size() == 0, "R5", "scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        finish_run;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 0, 1);
            finish_run;
        end
    end

endmodule